// File: doc/BRIEF.md
# Address-Latch Multicart Bank Mapper

This block sits on the cartridge side of an 8-bit console whose CPU has a 16-bit address bus. Every CPU write that lands in the upper 32KB of the address space stores the write address itself in a bank latch; the data byte on that write plays no part. From the latch the block forms the upper program-ROM address bits for whichever 16KB window the CPU is addressing (selected by CPU A14), the upper character-ROM address bits for a single 8KB window, and a nametable mirroring select.

The latch carries a chip-select bit that extends both bank numbers by one bit, a mode bit that chooses between one 32KB program bank and a mirrored 16KB bank, a 6-bit program bank field and a 6-bit character bank field. Bank outputs are combinational from the latch and CPU A14, so the first access after a switching write already sees the new bank.

A small register file of nibble-wide entries sits in the 0x5800–0x5FFF I/O region and can be written and read back by the CPU. All other reads below 0x8000 pass an externally supplied open-bus value through, with the valid flag low.

Top module: `addr_latch_mapper`

## Requirements
- R1: A write (cpu_we=1) to any address 0x8000–0xFFFF loads the latch from address bits 14–0 at the next rising clock edge; the data byte on that write has no effect on any output.
- R2: Writes to addresses below 0x8000 outside 0x5800–0x5FFF leave prg_bank, chr_bank and mirror_horiz unchanged and leave every register-file entry unchanged.
- R3: chr_bank equals {latched A14, latched A5–A0}.
- R4: mirror_horiz equals latched A13 (0 vertical, 1 horizontal).
- R5: With latched A12 = 0 (32KB mode), prg_bank equals {latched A14, latched A11–A7, cpu_addr[14]}, so the 0x8000 window gets the even bank and the 0xC000 window the odd one.
- R6: With latched A12 = 1 (16KB mode), prg_bank equals {latched A14, latched A11–A6} for both windows.
- R7: After reset the latch is all zero (prg_bank 0 at cpu_addr[14]=0, 1 at cpu_addr[14]=1, chr_bank 0, mirror_horiz 0) and every register-file entry reads 0.
- R8: A write to 0x5800–0x5FFF stores cpu_wdata[3:0] into the entry indexed by cpu_addr[1:0]; higher addresses in the range alias onto the same four entries.
- R9: When cpu_addr is in 0x5800–0x5FFF, rdata_valid is 1 and rdata is {4'b0000, indexed entry}.
- R10: When cpu_addr is outside 0x5800–0x5FFF, rdata_valid is 0 and rdata equals open_bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; latch and registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled at the rising edge |
| open_bus | input | 8 | Value passed through on reads the block does not answer |
| prg_bank | output | 7 | Program bank for the 16KB window addressed by cpu_addr[14] |
| chr_bank | output | 7 | Character bank for the 8KB window |
| mirror_horiz | output | 1 | Mirroring select, 1 = horizontal |
| rdata | output | 8 | Read data |
| rdata_valid | output | 1 | High when the block drives rdata from its register file |

## Verification
The bench builds the block with its default parameters: a 6-bit bank field and four nibble-wide entries, so the 7-bit bank outputs reach both chip-select halves and every register index is hit, with the 0x5804-style aliases landing on real entries. Random latch addresses cover both program modes, both mirroring values and both chip-select values, while random data bytes on latch writes and stray writes into 0x6000–0x7FFF and below 0x5800 show that neither disturbs the banks or the registers.

// File: rtl/addr_latch_mapper_pkg.sv
package addr_latch_mapper_pkg;
   localparam int BANK_FIELD_W = 6;
   localparam int BANK_W       = BANK_FIELD_W + 1;

   typedef struct packed {
      logic                    chip_sel;
      logic                    mirror_h;
      logic                    mode16;
      logic [BANK_FIELD_W-1:0] prg;
      logic [BANK_FIELD_W-1:0] chr;
   } bank_latch_t;

   localparam int LATCH_W = $bits(bank_latch_t);
endpackage

// File: rtl/mapper_bank_latch.sv
module mapper_bank_latch
   import addr_latch_mapper_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [14:0]       addr_low,
   output bank_latch_t       lat
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat <= '0;
      end else if (load) begin
         lat.chip_sel <= addr_low[14];
         lat.mirror_h <= addr_low[13];
         lat.mode16   <= addr_low[12];
         lat.prg      <= addr_low[2*BANK_FIELD_W-1:BANK_FIELD_W];
         lat.chr      <= addr_low[BANK_FIELD_W-1:0];
      end
   end
endmodule

// File: rtl/mapper_bank_calc.sv
module mapper_bank_calc
   import addr_latch_mapper_pkg::*;
#(
   parameter bit MODE16_SUPPORT = 1'b1
)(
   input  bank_latch_t       lat,
   input  logic              win_hi,
   output logic [BANK_W-1:0] prg_bank,
   output logic [BANK_W-1:0] chr_bank
);
   logic [BANK_W-1:0] prg_full;

   assign prg_full = {lat.chip_sel, lat.prg};
   assign chr_bank = {lat.chip_sel, lat.chr};

   generate
      if (MODE16_SUPPORT) begin : g_dual_mode
         always_comb begin
            if (lat.mode16) prg_bank = prg_full;
            else            prg_bank = {prg_full[BANK_W-1:1], win_hi};
         end
      end else begin : g_fixed32
         logic unused_mode;
         assign unused_mode = lat.mode16;
         assign prg_bank = {prg_full[BANK_W-1:1], win_hi};
      end
   endgenerate
endmodule

// File: rtl/mapper_nibble_regs.sv
module mapper_nibble_regs #(
   parameter int DEPTH  = 4,
   parameter int NIB_W  = 4,
   parameter int DATA_W = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [NIB_W-1:0] mem [DEPTH];

   generate
      if (NIB_W > DATA_W) begin : g_bad_width
         $error("NIB_W must not exceed DATA_W");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr) begin
         mem[idx] <= wdata[NIB_W-1:0];
      end
   end

   generate
      if (NIB_W == DATA_W) begin : g_full
         assign rdata = mem[idx];
      end else begin : g_pad
         assign rdata = {{(DATA_W-NIB_W){1'b0}}, mem[idx]};
      end
   endgenerate
endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
   import addr_latch_mapper_pkg::*;
#(
   parameter int RF_DEPTH       = 4,
   parameter int RF_NIB_W       = 4,
   parameter bit MODE16_SUPPORT = 1'b1,
   localparam int RF_IDX_W      = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic [7:0]        open_bus,
   output logic [BANK_W-1:0] prg_bank,
   output logic [BANK_W-1:0] chr_bank,
   output logic              mirror_horiz,
   output logic [7:0]        rdata,
   output logic              rdata_valid
);
   generate
      if (RF_DEPTH < 2 || RF_DEPTH > 2048) begin : g_bad_rf
         $error("RF_DEPTH must lie in 2..2048 to fit the register window");
      end
      if (BANK_FIELD_W != 6) begin : g_bad_field
         $error("latch layout needs a 6-bit bank field");
      end
   endgenerate

   bank_latch_t       lat;
   logic              in_upper;
   logic              in_regwin;
   logic [7:0]        rf_rdata;

   assign in_upper  = cpu_addr[15];
   assign in_regwin = (cpu_addr[15:11] == 5'b01011);

   mapper_bank_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cpu_we && in_upper),
      .addr_low (cpu_addr[14:0]),
      .lat      (lat)
   );

   mapper_bank_calc #(.MODE16_SUPPORT(MODE16_SUPPORT)) u_calc (
      .lat      (lat),
      .win_hi   (cpu_addr[14]),
      .prg_bank (prg_bank),
      .chr_bank (chr_bank)
   );

   mapper_nibble_regs #(.DEPTH(RF_DEPTH), .NIB_W(RF_NIB_W), .DATA_W(8)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cpu_we && in_regwin),
      .idx   (cpu_addr[RF_IDX_W-1:0]),
      .wdata (cpu_wdata),
      .rdata (rf_rdata)
   );

   assign mirror_horiz = lat.mirror_h;
   assign rdata_valid  = in_regwin;
   assign rdata        = in_regwin ? rf_rdata : open_bus;
endmodule

// File: rtl/addr_latch_mapper_chk.sv
module addr_latch_mapper_chk
   import addr_latch_mapper_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic              cpu_we,
   input logic [7:0]        open_bus,
   input logic [BANK_W-1:0] prg_bank,
   input logic [BANK_W-1:0] chr_bank,
   input logic              mirror_horiz,
   input logic [7:0]        rdata,
   input logic              rdata_valid,
   input bank_latch_t       lat
);
   AST_CHR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr[15]) |=> (chr_bank == {$past(cpu_addr[14]), $past(cpu_addr[5:0])})); // R3
   AST_MIRROR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr[15]) |=> (mirror_horiz == $past(cpu_addr[13]))); // R4
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && cpu_addr[15]) |=> ($stable(chr_bank) && $stable(mirror_horiz))); // R2
   AST_PAIR_32K: assert property (@(posedge clk) disable iff (!rst_n)
      !lat.mode16 |-> (prg_bank[0] == cpu_addr[14])); // R5
   AST_SAME_16K: assert property (@(posedge clk) disable iff (!rst_n)
      lat.mode16 |-> (prg_bank[BANK_W-1] == chr_bank[BANK_W-1])); // R6
   AST_NIBBLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> (rdata[7:4] == 4'h0)); // R9
   AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_valid |-> (rdata == open_bus)); // R10
endmodule

bind addr_latch_mapper addr_latch_mapper_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_addr     (cpu_addr),
   .cpu_we       (cpu_we),
   .open_bus     (open_bus),
   .prg_bank     (prg_bank),
   .chr_bank     (chr_bank),
   .mirror_horiz (mirror_horiz),
   .rdata        (rdata),
   .rdata_valid  (rdata_valid),
   .lat          (lat)
);

// File: tb/addr_latch_mapper_tb.sv
module addr_latch_mapper_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_wdata = 8'h00;
   logic        cpu_we = 1'b0;
   logic [7:0]  open_bus = 8'hA7;
   logic [6:0]  prg_bank;
   logic [6:0]  chr_bank;
   logic        mirror_horiz;
   logic [7:0]  rdata;
   logic        rdata_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [14:0] m_lat;
   logic [3:0]  m_reg [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_latch_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .open_bus(open_bus), .prg_bank(prg_bank),
      .chr_bank(chr_bank), .mirror_horiz(mirror_horiz), .rdata(rdata),
      .rdata_valid(rdata_valid));

   function automatic logic [6:0] exp_prg(logic [14:0] l, logic hi);
      logic [6:0] full;
      full = {l[14], l[11:6]};
      return l[12] ? full : {full[6:1], hi};
   endfunction

   function automatic logic [6:0] exp_chr(logic [14:0] l);
      return {l[14], l[5:0]};
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      if (a[15]) m_lat = a[14:0];
      else if (a[15:11] == 5'b01011) m_reg[a[1:0]] = d[3:0];
   endtask

   task automatic probe_banks(string tag);
      cpu_addr = 16'h8123; #1;
      check({tag, " R5/R6 low window"}, 16'(prg_bank), 16'(exp_prg(m_lat, 1'b0)));
      cpu_addr = 16'hC456; #1;
      check({tag, " R5/R6 high window"}, 16'(prg_bank), 16'(exp_prg(m_lat, 1'b1)));
      check({tag, " R3 chr"}, 16'(chr_bank), 16'(exp_chr(m_lat)));
      check({tag, " R4 mirror"}, 16'(mirror_horiz), 16'(m_lat[13]));
   endtask

   task automatic probe_read(string tag, logic [15:0] a);
      logic win;
      cpu_addr = a; open_bus = 8'($urandom); #1;
      win = (a[15:11] == 5'b01011);
      if (win) begin
         check({tag, " R9 valid"}, 16'(rdata_valid), 16'd1);
         check({tag, " R9 data"}, 16'(rdata), 16'({4'h0, m_reg[a[1:0]]}));
      end else begin
         check({tag, " R10 valid"}, 16'(rdata_valid), 16'd0);
         check({tag, " R10 data"}, 16'(rdata), 16'(open_bus));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0255));
      m_lat = '0;
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state
      cpu_addr = 16'h8000; #1;
      check("R7 prg low after reset", 16'(prg_bank), 16'd0);
      cpu_addr = 16'hC000; #1;
      check("R7 prg high after reset", 16'(prg_bank), 16'd1);
      check("R7 chr after reset", 16'(chr_bank), 16'd0);
      check("R7 mirror after reset", 16'(mirror_horiz), 16'd0);
      for (int i = 0; i < 4; i++) begin
         cpu_addr = 16'h5800 + 16'(i); #1;
         check("R7 reg after reset", 16'(rdata), 16'd0);
      end

      // R5: 32KB mode bank 4 -> 4/5, data ignored (R1)
      do_write(16'h8100, 8'hFF);
      cpu_addr = 16'h8000; #1; check("R5 32K low", 16'(prg_bank), 16'd4);
      cpu_addr = 16'hC000; #1; check("R5 32K high", 16'(prg_bank), 16'd5);
      // R6: 16KB mode with chip select -> 66 in both windows
      do_write(16'hD080, 8'h00);
      cpu_addr = 16'h8000; #1; check("R6 16K low", 16'(prg_bank), 16'd66);
      cpu_addr = 16'hC000; #1; check("R6 16K high", 16'(prg_bank), 16'd66);
      // R3 / R4
      do_write(16'h8005, 8'h3C);
      check("R3 chr 5", 16'(chr_bank), 16'd5);
      check("R4 vertical", 16'(mirror_horiz), 16'd0);
      do_write(16'hA000, 8'h00);
      check("R4 horizontal", 16'(mirror_horiz), 16'd1);
      // R2: stray writes below 0x8000 do nothing
      do_write(16'h7FFF, 8'h55);
      do_write(16'h57FF, 8'h0F);
      do_write(16'h6000, 8'h0F);
      probe_banks("R2 directed");
      probe_read("R2 regs untouched", 16'h5803);
      // R8: nibble store and alias
      do_write(16'h5800, 8'hFF);
      probe_read("R8 nibble", 16'h5800);
      do_write(16'h5801, 8'hA5);
      probe_read("R8 idx1", 16'h5801);
      do_write(16'h5804, 8'h03);
      probe_read("R8 alias", 16'h5800);
      do_write(16'h5FFE, 8'h9C);
      probe_read("R8 top alias", 16'h5802);
      // R10: boundaries
      probe_read("R10 below", 16'h57FF);
      probe_read("R10 above", 16'h6000);
      probe_read("R10 rom", 16'h8000);

      for (int n = 0; n < 400; n++) begin
         logic [15:0] a;
         int kind;
         kind = int'($urandom_range(0, 2));
         case (kind)
            0: a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
            1: a = 16'h5800 | 16'($urandom_range(0, 16'h07FF));
            default: a = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 16'h57FF))
                                                      : 16'($urandom_range(16'h6000, 16'h7FFF));
         endcase
         do_write(a, 8'($urandom));
         probe_banks("R1 random");
         probe_read("R8 random", 16'h5800 | 16'($urandom_range(0, 16'h07FF)));
         probe_read("R10 random", 16'($urandom_range(0, 16'hFFFF)));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule